// File: doc/BRIEF.md
# Latency Tolerance Reporting Controller

This block decides when a device tells the platform how much service latency it can tolerate, and what that figure is. A relaxed tolerance lets the platform drop into deeper, slower-to-exit power states. A tight tolerance keeps the platform responsive. The block produces a 14-bit encoded tolerance and offers it to the transaction layer over a valid/ready handshake. It does not build the packet itself.

In hardware mode, the device's own activity picks the value. While traffic flows, the block reports the active tolerance. After a stretch with no arriving data, it reports the relaxed active-idle tolerance. When receive-buffer occupancy climbs to a wake level, it returns to the active tolerance at once. That wake level sits below the overrun point, because a new figure is only guaranteed to take hold within the latency reported before it. A sleep input selects the platform maximum instead. If the device also flags that it has no peer, the block reports "no requirement".

In software mode, a register write chooses the value. A written value tighter than the active tolerance is treated as a short burst and reverts on its own. Every reported value is clamped to the platform maximum supplied by firmware. Messages go out only when the encoded value changes.

Top module: `ltr_ctrl`

## Requirements
- R1: After reset `msg_valid` is low, and no message is offered while `en` is low.
- R2: The code places the requirement flag in bit 13, a scale s in bits 12:10 and a magnitude in bits 9:0. The tolerance in ns is magnitude × 32^s. The magnitude is floor(ns / 32^s), using the smallest s that gives a magnitude below 1024. "No requirement" is the all-zero code.
- R3: Clearing `en` drops any pending request and suppresses messages. Each rise of `en` offers the current value once, even if it equals the last one sent.
- R4: While enabled, a new message is offered only when the encoded target differs from the last accepted code.
- R5: `msg_valid` stays high with a stable `msg_code` until `msg_ready` accepts it. Target changes made while a message waits merge into one later message that carries the latest value.
- R6: In hardware mode the block reports ACT_US while active. It moves to AIDLE_US once IDLE_TO_CYC cycles pass without an `rx_push`. Reset leaves it in the active state with the timer cleared.
- R7: In the active-idle state, `rx_level` at or above WAKE_LVL returns the block to ACT_US. In the active state, each `rx_push` restarts the inactivity timer.
- R8: In hardware mode with `dev_sleep` high, the block reports `plat_max_us`. If `unassoc` is also high, it reports "no requirement".
- R9: No reported tolerance exceeds `plat_max_us`. Larger selections are clamped to it.
- R10: `sw_wr` stores `sw_us`. In software mode the stored value is the target.
- R11: In software mode, a stored value below ACT_US holds for BURST_CYC cycles and is then replaced by ACT_US.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Reporting enable from configuration |
| plat_max_us | input | US_W | Platform maximum latency, µs |
| sw_mode | input | 1 | 1 = software-guided, 0 = hardware-driven |
| sw_wr | input | 1 | Software register write strobe |
| sw_us | input | US_W | Software-written tolerance, µs |
| rx_push | input | 1 | Receive data arrival pulse |
| rx_level | input | LVL_W | Receive buffer occupancy |
| dev_sleep | input | 1 | Device deeply idle (for example, radio off) |
| unassoc | input | 1 | No peer; report no requirement when asleep |
| msg_valid | output | 1 | Message request |
| msg_ready | input | 1 | Transaction layer accepts the message |
| msg_code | output | 14 | Encoded tolerance payload |

## Verification
The software path is swept across a ladder of tolerances from 97 µs to 948 µs. Each step is compared with an encoding computed independently in the bench, which separates scale-selection and truncation errors from path errors. Hardware-mode patterns probe the inactivity boundary: a level one below the wake point, a level at the wake point, and steady pushes faster than the timeout. Together these tell a level-triggered wake apart from timer restarts. Holding `msg_ready` low while several targets change shows whether stale intermediate values leak out. Enable toggles with an unchanged value show the forced resend, and a clamped platform maximum shows the limit.

// File: rtl/ltr_ctrl.sv
module ltr_ctrl #(
  parameter int US_W        = 16,
  parameter int LVL_W       = 6,
  parameter int IDLE_TO_CYC = 32,
  parameter int BURST_CYC   = 16,
  parameter int WAKE_LVL    = 8,
  parameter int ACT_US      = 60,
  parameter int AIDLE_US    = 400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [US_W-1:0]  plat_max_us,
  input  logic             sw_mode,
  input  logic             sw_wr,
  input  logic [US_W-1:0]  sw_us,
  input  logic             rx_push,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             dev_sleep,
  input  logic             unassoc,
  output logic             msg_valid,
  input  logic             msg_ready,
  output logic [13:0]      msg_code
);
  localparam int TO_W = $clog2(IDLE_TO_CYC + 1);
  localparam int BU_W = $clog2(BURST_CYC + 1);
  localparam logic [US_W-1:0] ACT_V   = US_W'(ACT_US);
  localparam logic [US_W-1:0] AIDLE_V = US_W'(AIDLE_US);

  function automatic logic [13:0] encode(input logic [US_W-1:0] us);
    logic [31:0] ns;
    logic [31:0] m;
    logic [2:0]  sc;
    ns = 32'(us) * 32'd1000;
    sc = 3'd5;
    for (int s = 4; s >= 0; s--)
      if ((ns >> (5 * s)) < 32'd1024) sc = 3'(s);
    m = ns >> (5 * int'(sc));
    return {1'b1, sc, m[9:0]};
  endfunction

  function automatic logic [31:0] decode_ns(input logic [13:0] c);
    return 32'(c[9:0]) << (5 * int'(c[12:10]));
  endfunction

  logic             aidle_q;
  logic [TO_W-1:0]  to_cnt;
  logic [US_W-1:0]  sw_q;
  logic [BU_W-1:0]  bu_cnt;
  logic             valid_q, synced_q;
  logic [13:0]      code_q, last_q;

  logic [US_W-1:0]  hw_us, sel_us, clamp_us;
  logic             no_req;
  logic [13:0]      target;

  assign hw_us    = aidle_q ? AIDLE_V : ACT_V;
  assign sel_us   = sw_mode ? sw_q : (dev_sleep ? plat_max_us : hw_us);
  assign no_req   = !sw_mode && dev_sleep && unassoc;
  assign clamp_us = (sel_us > plat_max_us) ? plat_max_us : sel_us;
  assign target   = no_req ? 14'd0 : encode(clamp_us);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aidle_q <= 1'b0;
      to_cnt  <= '0;
    end else if (aidle_q) begin
      if (rx_level >= LVL_W'(WAKE_LVL)) begin
        aidle_q <= 1'b0;
        to_cnt  <= '0;
      end
    end else if (rx_push) begin
      to_cnt <= '0;
    end else if (to_cnt == TO_W'(IDLE_TO_CYC - 1)) begin
      aidle_q <= 1'b1;
      to_cnt  <= '0;
    end else begin
      to_cnt <= to_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q   <= ACT_V;
      bu_cnt <= '0;
    end else if (sw_wr) begin
      sw_q   <= sw_us;
      bu_cnt <= '0;
    end else if (sw_mode && sw_q < ACT_V) begin
      if (bu_cnt == BU_W'(BURST_CYC - 1)) begin
        sw_q   <= ACT_V;
        bu_cnt <= '0;
      end else begin
        bu_cnt <= bu_cnt + 1'b1;
      end
    end else begin
      bu_cnt <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      synced_q <= 1'b0;
      code_q   <= '0;
      last_q   <= '0;
    end else if (!en) begin
      valid_q  <= 1'b0;
      synced_q <= 1'b0;
    end else if (valid_q && msg_ready) begin
      valid_q  <= 1'b0;
      last_q   <= code_q;
      synced_q <= 1'b1;
    end else if (!valid_q && (!synced_q || target != last_q)) begin
      valid_q <= 1'b1;
      code_q  <= target;
    end
  end

  assign msg_valid = valid_q;
  assign msg_code  = code_q;

  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready && en) |=> (!en || (msg_valid && $stable(msg_code))));

  a_r3_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !msg_valid);

  a_r9_within_max: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(msg_valid) && msg_code[13]) |->
      (decode_ns(msg_code) <= 32'($past(plat_max_us)) * 32'd1000));

  a_r2_noreq_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_code[13]) |-> (msg_code[12:0] == 13'd0));

  a_r11_burst_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_mode && !sw_wr && sw_q < ACT_V) |-> (bu_cnt < BU_W'(BURST_CYC)));
endmodule

// File: tb/ltr_ctrl_tb_top.sv
module ltr_ctrl_tb_top;
  localparam int IDLE_TO = 32, BURST = 16, WAKE = 8;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [15:0] plat_max_us = 16'd1000, sw_us = '0;
  logic sw_mode = 1'b0, sw_wr = 1'b0, rx_push = 1'b0, dev_sleep = 1'b0, unassoc = 1'b0;
  logic [5:0] rx_level = '0;
  logic msg_valid, msg_ready = 1'b1;
  logic [13:0] msg_code;

  int checks = 0, fails = 0, n = 0, rd = 0, cyc = 0;
  logic [13:0] log_q [0:255];

  always #2.5 clk = ~clk;

  ltr_ctrl #(.IDLE_TO_CYC(IDLE_TO), .BURST_CYC(BURST), .WAKE_LVL(WAKE)) dut_i (
    .clk, .rst_n, .en, .plat_max_us, .sw_mode, .sw_wr, .sw_us, .rx_push, .rx_level,
    .dev_sleep, .unassoc, .msg_valid, .msg_ready, .msg_code);

  always @(negedge clk) begin
    cyc++;
    if (rst_n && msg_valid && msg_ready && n < 256) begin
      log_q[n] = msg_code;
      n++;
    end
  end

  function automatic logic [13:0] exp_code(input int us, input int pmax);
    longint ns;
    int v = (us > pmax) ? pmax : us;
    ns = longint'(v) * 1000;
    for (int s = 0; s < 6; s++)
      if (ns / (longint'(1) << (5 * s)) < 1024)
        return {1'b1, 3'(s), 10'(ns / (longint'(1) << (5 * s)))};
    return 14'h3fff;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic expect_next(input logic [13:0] e, input string req);
    int t = 0;
    while (n <= rd && t < 100) begin @(negedge clk); t++; end
    if (n <= rd) check(0, req, -1, e);
    else begin check(log_q[rd] == e, req, log_q[rd], e); rd++; end
  endtask

  task automatic expect_none(input string req);
    check(n == rd, req, n, rd);
  endtask

  task automatic swr(input int v);
    sw_us = 16'(v); sw_wr = 1'b1; @(negedge clk); sw_wr = 1'b0;
  endtask

  initial begin
    wait (cyc > 150000);
    check(0, "watchdog", cyc, 150000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    check(msg_valid == 1'b0, "R1 reset", msg_valid, 0);
    cycles(10);
    expect_none("R1 off");

    // hardware mode, active value on enable
    en = 1'b1;
    expect_next(exp_code(60, 1000), "R3/R6 first active");
    cycles(5);
    expect_none("R4 no repeat");

    // inactivity moves to active-idle
    cycles(IDLE_TO + 5);
    expect_next(exp_code(400, 1000), "R6 timeout");
    expect_none("R4 single idle msg");

    rx_level = 6'(WAKE - 1);
    cycles(8);
    expect_none("R7 below wake");
    rx_level = 6'(WAKE);
    expect_next(exp_code(60, 1000), "R7 wake");
    rx_level = '0;

    for (int i = 0; i < 8; i++) begin
      rx_push = 1'b1; @(negedge clk); rx_push = 1'b0;
      cycles(IDLE_TO / 2);
    end
    expect_none("R7 push restarts timer");

    dev_sleep = 1'b1;
    expect_next(exp_code(1000, 1000), "R8 sleep max");
    unassoc = 1'b1;
    expect_next(14'd0, "R8/R2 no requirement");
    cycles(IDLE_TO + 5);
    unassoc = 1'b0; dev_sleep = 1'b0; plat_max_us = 16'd200;
    expect_next(exp_code(200, 200), "R9 clamp");
    plat_max_us = 16'd1000;
    expect_next(exp_code(400, 1000), "R9 unclamped");

    // handshake hold and merge
    msg_ready = 1'b0;
    dev_sleep = 1'b1;
    cycles(2);
    check(msg_valid && msg_code == exp_code(1000, 1000), "R5 pending", msg_code, exp_code(1000, 1000));
    dev_sleep = 1'b0;
    cycles(3);
    plat_max_us = 16'd300;
    cycles(4);
    check(msg_valid && msg_code == exp_code(1000, 1000), "R5 held", msg_code, exp_code(1000, 1000));
    msg_ready = 1'b1;
    expect_next(exp_code(1000, 1000), "R5 first");
    expect_next(exp_code(300, 300), "R5 merged");
    cycles(5);
    expect_none("R5 no stale");
    plat_max_us = 16'd1000;
    expect_next(exp_code(400, 1000), "R9 restore");

    // software mode sweep
    sw_mode = 1'b1;
    expect_next(exp_code(60, 1000), "R10 default");
    for (int k = 1; k < 25; k++) begin
      swr(60 + 37 * k);
      expect_next(exp_code(60 + 37 * k, 1000), "R10/R2 sweep");
    end
    swr(1200);
    expect_next(exp_code(1000, 1000), "R9 sw clamp");
    swr(1200);
    cycles(5);
    expect_none("R4 same write");

    swr(20);
    expect_next(exp_code(20, 1000), "R11 burst value");
    cycles(8);
    expect_none("R11 burst held");
    expect_next(exp_code(60, 1000), "R11 fallback");

    // enable gating
    en = 1'b0;
    swr(500);
    cycles(5);
    expect_none("R3 suppressed");
    check(msg_valid == 1'b0, "R3 valid low", msg_valid, 0);
    en = 1'b1;
    expect_next(exp_code(500, 1000), "R3 on rise");
    en = 1'b0; cycles(2); en = 1'b1;
    expect_next(exp_code(500, 1000), "R3 resend");
    cycles(5);
    expect_none("R4 after resend");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule